// File: doc/BRIEF.md
# Four-Way Cache Victim Selector

This block decides which way of a four-way set-associative cache receives a newly fetched line after a miss. The cache controller presents the valid bits of the addressed set and pulses a replace request. One cycle later the block returns the chosen way with a single-cycle strobe. Ways that hold no line are filled first, always starting from the lowest number.

Once every way is occupied, the choice comes from a small counter. The counter is cleared by reset and by a cache-wide invalidate command, so two identical systems running the same access stream make the same choices. During a software flush, a mode input makes the block return a way named by software, and the counter takes no part.

Top module: `way_victim_sel`

## Requirements
- R1: After reset `victim_vld` is 0, `victim_way` is 0 and the internal counter is 0, so the first all-valid replacement returns way 0.
- R2: A request (`repl_req`=1 with `inv_all`=0) gives `victim_vld`=1 for exactly the following cycle. No other cycle has `victim_vld`=1. Requests in consecutive cycles give strobes in consecutive cycles.
- R3: When `flush_mode`=0 and at least one bit of `set_valid` is 0 (bit i is way i, 1 means the way holds a line), the victim is the lowest index whose bit is 0.
- R4: When `flush_mode`=0 and all four bits of `set_valid` are 1, the victim equals the counter value. Starting from 0, successive such replacements return 0, 1, 2, 3 and then 0 again.
- R5: The counter advances by one only on a request served under R4. Requests served under R3 or R6 leave it unchanged.
- R6: When `flush_mode`=1, the victim is `flush_way` regardless of `set_valid`.
- R7: An `inv_all` pulse clears the counter to 0.
- R8: If `inv_all` and `repl_req` are high in the same cycle, the invalidate wins. No strobe follows that cycle, and the counter is 0 for the next replacement.
- R9: `victim_way` keeps its last value in every cycle that follows a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_valid | input | 4 | Valid bit per way of the addressed set |
| repl_req | input | 1 | Replace request strobe |
| inv_all | input | 1 | Cache-wide invalidate strobe; clears the counter |
| flush_mode | input | 1 | 1 forces the victim to `flush_way` |
| flush_way | input | 2 | Software-selected way used in flush mode |
| victim_way | output | 2 | Registered victim way |
| victim_vld | output | 1 | One-cycle strobe marking a new victim |

## Verification
Two functions can land in the same cycle: a replace request and the global invalidate. The bench raises both in one cycle while every way is valid and the counter is non-zero, then idles for one cycle. Any strobe in that idle cycle counts as a failure. The bench then issues one all-valid request and expects way 0 from it, which shows that the counter was cleared and the dropped request did not advance it.

// File: rtl/victim_pkg.sv
package victim_pkg;

    // Which rule produced the victim
    typedef enum logic [1:0] {
        SRC_FREE  = 2'd0,
        SRC_CTR   = 2'd1,
        SRC_FLUSH = 2'd2
    } victim_src_e;

endpackage

// File: rtl/victim_free_enc.sv
// Lowest-index invalid way finder
module victim_free_enc #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0] valid_i,
    output logic                any_free_o,
    output logic [WAY_W-1:0]    free_way_o
);

    always_comb begin
        free_way_o = '0;
        // scan from the top so the lowest free index is written last
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                free_way_o = WAY_W'(i);
            end
        end
        any_free_o = ~&valid_i;
    end

endmodule

// File: rtl/victim_src_mux.sv
// Chooses between flush way, free way and counter value
module victim_src_mux
    import victim_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic             flush_mode_i,
    input  logic [WAY_W-1:0] flush_way_i,
    input  logic             any_free_i,
    input  logic [WAY_W-1:0] free_way_i,
    input  logic [WAY_W-1:0] ctr_i,
    output logic [WAY_W-1:0] pick_way_o,
    output victim_src_e      src_o
);

    always_comb begin
        if (flush_mode_i) begin
            pick_way_o = flush_way_i;
            src_o      = SRC_FLUSH;
        end else if (any_free_i) begin
            pick_way_o = free_way_i;
            src_o      = SRC_FREE;
        end else begin
            pick_way_o = ctr_i;
            src_o      = SRC_CTR;
        end
    end

endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel
    import victim_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_WAYS-1:0] set_valid,
    input  logic                repl_req,
    input  logic                inv_all,
    input  logic                flush_mode,
    input  logic [WAY_W-1:0]    flush_way,
    output logic [WAY_W-1:0]    victim_way,
    output logic                victim_vld
);

    typedef struct packed {
        logic [WAY_W-1:0] way;
        logic             vld;
        logic [WAY_W-1:0] ctr;
    } sel_state_t;

    sel_state_t  s_d, s_q;
    logic        any_free;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] pick_way;
    victim_src_e src;
    logic        take;
    logic [WAY_W-1:0] ctr_q;

    assign ctr_q = s_q.ctr;

    victim_free_enc #(.NUM_WAYS(NUM_WAYS)) u_free (
        .valid_i    (set_valid),
        .any_free_o (any_free),
        .free_way_o (free_way)
    );

    victim_src_mux #(.NUM_WAYS(NUM_WAYS)) u_mux (
        .flush_mode_i (flush_mode),
        .flush_way_i  (flush_way),
        .any_free_i   (any_free),
        .free_way_i   (free_way),
        .ctr_i        (s_q.ctr),
        .pick_way_o   (pick_way),
        .src_o        (src)
    );

    assign take = repl_req && !inv_all;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (inv_all) begin
            // invalidate wins over a same-cycle request
            s_d.ctr = '0;
        end else if (take) begin
            s_d.way = pick_way;
            s_d.vld = 1'b1;
            if (src == SRC_CTR) begin
                s_d.ctr = s_q.ctr + WAY_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign victim_way = s_q.way;
    assign victim_vld = s_q.vld;

endmodule

// File: rtl/victim_sel_chk.sv
module victim_sel_chk #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_WAYS-1:0] set_valid,
    input logic                repl_req,
    input logic                inv_all,
    input logic                flush_mode,
    input logic [WAY_W-1:0]    flush_way,
    input logic [WAY_W-1:0]    victim_way,
    input logic                victim_vld,
    input logic [WAY_W-1:0]    ctr_q
);

    // R2
    strobe_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (repl_req && !inv_all) |=> victim_vld);

    // R2
    no_stray_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(repl_req && !inv_all) |=> !victim_vld);

    // R6
    flush_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (repl_req && !inv_all && flush_mode) |=> (victim_way == $past(flush_way)));

    // R3
    lowest_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (repl_req && !inv_all && !flush_mode && !set_valid[0]) |=> (victim_way == '0));

    // R7
    inv_clears_ctr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (ctr_q == '0));

    // R5
    ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inv_all && !(repl_req && !flush_mode && (&set_valid))) |=> $stable(ctr_q));

    // R9
    way_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(repl_req && !inv_all) |=> $stable(victim_way));

endmodule

bind way_victim_sel victim_sel_chk #(.NUM_WAYS(NUM_WAYS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_valid  (set_valid),
    .repl_req   (repl_req),
    .inv_all    (inv_all),
    .flush_mode (flush_mode),
    .flush_way  (flush_way),
    .victim_way (victim_way),
    .victim_vld (victim_vld),
    .ctr_q      (ctr_q)
);

// File: tb/way_victim_sel_test.sv
`timescale 1ns/1ps
module way_victim_sel_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] set_valid = '0;
    logic       repl_req = 1'b0;
    logic       inv_all = 1'b0;
    logic       flush_mode = 1'b0;
    logic [1:0] flush_way = '0;
    logic [1:0] victim_way;
    logic       victim_vld;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [1:0] exp_q[$];
    string      tag_q[$];
    logic [1:0] last_way = '0;
    logic       done = 1'b0;

    always #2 clk = ~clk;

    way_victim_sel uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_valid  (set_valid),
        .repl_req   (repl_req),
        .inv_all    (inv_all),
        .flush_mode (flush_mode),
        .flush_way  (flush_way),
        .victim_way (victim_way),
        .victim_vld (victim_vld)
    );

    // monitor: pops expected victims as strobes appear
    always @(negedge clk) begin
        if (rst_n && victim_vld && !done) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R2/R8: unexpected strobe, way=%0d expected no strobe", victim_way);
            end else begin
                logic [1:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (victim_way !== e) begin
                    bad++;
                    $display("FAIL %s: victim_way=%0d expected %0d", t, victim_way, e);
                end
                last_way = e;
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog: cycles=%0d expected under 20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            repl_req = 1'b0;
            inv_all  = 1'b0;
        end
    endtask

    task automatic repl(input logic [3:0] v, input logic fm, input logic [1:0] fw,
                        input logic [1:0] e, input string t);
        @(negedge clk);
        set_valid  = v;
        flush_mode = fm;
        flush_way  = fw;
        repl_req   = 1'b1;
        inv_all    = 1'b0;
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic check(input logic ok, input string t, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    initial begin
        idle(3);
        // R1 reset state
        check(victim_vld === 1'b0, "R1 vld", victim_vld, 0);
        check(victim_way === 2'd0, "R1 way", victim_way, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R4 counter sequence, back to back (R2 consecutive strobes)
        repl(4'hF, 1'b0, 2'd0, 2'd0, "R1/R4");
        repl(4'hF, 1'b0, 2'd0, 2'd1, "R4");
        repl(4'hF, 1'b0, 2'd0, 2'd2, "R4");
        repl(4'hF, 1'b0, 2'd0, 2'd3, "R4");
        repl(4'hF, 1'b0, 2'd0, 2'd0, "R4 wrap");
        idle(2);

        // R3 lowest invalid way
        repl(4'b1110, 1'b0, 2'd0, 2'd0, "R3");
        repl(4'b1101, 1'b0, 2'd0, 2'd1, "R3");
        repl(4'b1011, 1'b0, 2'd0, 2'd2, "R3");
        repl(4'b0111, 1'b0, 2'd0, 2'd3, "R3");
        repl(4'b0101, 1'b0, 2'd0, 2'd1, "R3");
        repl(4'b0000, 1'b0, 2'd0, 2'd0, "R3");
        idle(1);

        // R5 counter did not move during free fills (still 1)
        repl(4'hF, 1'b0, 2'd0, 2'd1, "R5");
        idle(1);

        // R6 flush mode overrides valid bits, counter untouched
        repl(4'b0000, 1'b1, 2'd3, 2'd3, "R6");
        repl(4'hF, 1'b1, 2'd0, 2'd0, "R6");
        repl(4'hF, 1'b1, 2'd2, 2'd2, "R6");
        repl(4'hF, 1'b0, 2'd0, 2'd2, "R5/R6");
        idle(3);

        // R9 way holds when idle
        check(victim_vld === 1'b0, "R9 vld idle", victim_vld, 0);
        check(victim_way === last_way, "R9 hold", victim_way, last_way);

        // R7 invalidate alone clears counter (now 3)
        @(negedge clk);
        inv_all = 1'b1;
        idle(2);
        check(victim_vld === 1'b0, "R7 no strobe", victim_vld, 0);
        repl(4'hF, 1'b0, 2'd0, 2'd0, "R7");
        repl(4'hF, 1'b0, 2'd0, 2'd1, "R7");
        idle(2);

        // R8 invalidate with same-cycle request (counter now 2)
        @(negedge clk);
        set_valid  = 4'hF;
        flush_mode = 1'b0;
        repl_req   = 1'b1;
        inv_all    = 1'b1;
        idle(1);
        check(victim_vld === 1'b0, "R8 dropped request", victim_vld, 0);
        idle(1);
        repl(4'hF, 1'b0, 2'd0, 2'd0, "R8");
        idle(4);

        // R2 every request produced its strobe
        check(exp_q.size() == 0, "R2 missing strobes", exp_q.size(), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule